// File: doc/BRIEF.md
# Microcoded Accumulator Core

This core executes a small accumulator instruction set without any hard-wired instruction decoding. Each clock cycle one 20-bit microinstruction is read from a 128-word control store. It carries three microoperation selectors, a condition selector, a sequencing action and a 7-bit target address. A sequencer works out the next control address from these fields. It can step to the next address, jump, call a one-deep subroutine, return, or decode the opcode of the fetched instruction into the start address of its routine. The datapath holds a program counter, an address register, a data register, an accumulator and a word memory.

An instruction word is 16 bits. Bit 15 is the indirect flag, bits 14:11 hold the opcode and bits 10:0 hold the address. The opcode values are add = 0, conditional branch = 1, store = 2 and exchange = 3. A shared fetch routine starts at control address 64. It copies PC to AR, then reads memory and increments PC in the same step, then copies the address field to AR while it decodes. The decode sends the opcode to control address opcode×4. When the indirect flag is set, a shared subroutine at control address 67 replaces AR with the word it points to.

Memory contents are loaded through a port that writes only while reset is held. Any memory word can be read at any time through a separate combinational peek port.

Top module: `uacc_core`

## Requirements
- R1: While reset is high, the control address becomes 64 and PC, AR, DR and AC become zero.
- R2: Every instruction starts with the three-step fetch at control addresses 64, 65 and 66. The fetch leaves PC one above the address of the fetched word and loads AR with bits 10:0 of that word.
- R3: The decode step moves to control address {0, opcode[3:0], 00}, which is opcode×4.
- R4: ADD (opcode 0) adds the operand at the effective address to AC, with wrap-around at 16 bits. From one fetch start to the next it takes 6 cycles when direct and 8 cycles when indirect.
- R5: BRANCH (opcode 1) loads PC with the effective address when AC bit 15 is 1, which takes 6 cycles direct or 8 cycles indirect. When AC bit 15 is 0 it leaves PC at the next word after 5 cycles.
- R6: STORE (opcode 2) writes AC to the effective address and leaves AC unchanged. It takes 6 cycles direct and 8 cycles indirect.
- R7: EXCHANGE (opcode 3) loads AC with the old operand and writes the old AC to the effective address, in 7 cycles when direct.
- R8: When bit 15 is set, the effective address is bits 10:0 of the word at the address field. The pointer word itself is not modified, and the indirect subroutine returns to the step after the call.
- R9: Opcodes 4 to 15 change nothing except PC, which moves to the next word. Each takes 4 cycles.
- R10: A memory write requested on the load port while reset is low is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also enables the load port |
| ld_we | input | 1 | Load-port write strobe, honoured only during reset |
| ld_addr | input | 11 | Load-port word address |
| ld_data | input | 16 | Load-port write data |
| peek_addr | input | 11 | Address of the memory word shown on peek_data |
| peek_data | output | 16 | Combinational memory read data |
| pc_q | output | 11 | Program counter |
| ar_q | output | 11 | Address register |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| uaddr | output | 7 | Current control-store address |

## Verification
A wrong sequencing decision in this core is visible on uaddr in the very next cycle. It also shows up as a wrong fetch-to-fetch cycle count for the instruction being executed, so the bench times every instruction. A wrong microoperation shows up in PC, AR or AC by the next fetch start, or as a wrong memory word on the peek port once a store or exchange has finished. Indirect and negative-accumulator paths need dedicated programs, because a direct program with a positive accumulator never enters the indirect subroutine or the taken-branch routine.

// File: rtl/uacc_pkg.sv
package uacc_pkg;

    localparam int CA_W = 7;

    typedef enum logic [2:0] {
        F1_NOP, F1_ADD_DR, F1_CLR_AC, F1_INC_AC,
        F1_DR_TO_AC, F1_DR_TO_AR, F1_PC_TO_AR, F1_MEM_WR
    } f1_e;

    typedef enum logic [2:0] {
        F2_NOP, F2_SUB_DR, F2_OR_DR, F2_AND_DR,
        F2_MEM_RD, F2_AC_TO_DR, F2_INC_DR, F2_PC_TO_DR
    } f2_e;

    typedef enum logic [2:0] {
        F3_NOP, F3_XOR_DR, F3_NOT_AC, F3_SHL_AC,
        F3_SHR_AC, F3_INC_PC, F3_AR_TO_PC, F3_SPARE
    } f3_e;

    typedef enum logic [1:0] {C_ALWAYS, C_IND, C_NEG, C_ZERO} cond_e;
    typedef enum logic [1:0] {S_JUMP, S_CALL, S_RETURN, S_DECODE} seq_e;

    typedef struct packed {
        f1_e              f1;
        f2_e              f2;
        f3_e              f3;
        cond_e            cd;
        seq_e             br;
        logic [CA_W-1:0]  ad;
    } uinstr_t;

    // control-store entry points
    localparam logic [CA_W-1:0] UA_ADD       = 7'd0;
    localparam logic [CA_W-1:0] UA_ADD_RD    = 7'd1;
    localparam logic [CA_W-1:0] UA_ADD_SUM   = 7'd2;
    localparam logic [CA_W-1:0] UA_BRN       = 7'd4;
    localparam logic [CA_W-1:0] UA_BRN_SKIP  = 7'd5;
    localparam logic [CA_W-1:0] UA_BRN_TAKE  = 7'd6;
    localparam logic [CA_W-1:0] UA_BRN_LOAD  = 7'd7;
    localparam logic [CA_W-1:0] UA_STO       = 7'd8;
    localparam logic [CA_W-1:0] UA_STO_MOV   = 7'd9;
    localparam logic [CA_W-1:0] UA_STO_WR    = 7'd10;
    localparam logic [CA_W-1:0] UA_XCH       = 7'd12;
    localparam logic [CA_W-1:0] UA_XCH_RD    = 7'd13;
    localparam logic [CA_W-1:0] UA_XCH_SWAP  = 7'd14;
    localparam logic [CA_W-1:0] UA_XCH_WR    = 7'd15;
    localparam logic [CA_W-1:0] UA_FETCH     = 7'd64;
    localparam logic [CA_W-1:0] UA_FETCH_RD  = 7'd65;
    localparam logic [CA_W-1:0] UA_FETCH_DEC = 7'd66;
    localparam logic [CA_W-1:0] UA_IND       = 7'd67;
    localparam logic [CA_W-1:0] UA_IND_RET   = 7'd68;

    function automatic uinstr_t mk(f1_e a, f2_e b, f3_e c, cond_e d, seq_e e,
                                   logic [CA_W-1:0] t);
        uinstr_t u;
        u.f1 = a;
        u.f2 = b;
        u.f3 = c;
        u.cd = d;
        u.br = e;
        u.ad = t;
        return u;
    endfunction

    // microprogram; unlisted words fall back to the fetch routine
    function automatic uinstr_t ucode(logic [CA_W-1:0] a);
        case (a)
            UA_ADD:       return mk(F1_NOP,      F2_NOP,      F3_NOP,      C_IND,    S_CALL,   UA_IND);
            UA_ADD_RD:    return mk(F1_NOP,      F2_MEM_RD,   F3_NOP,      C_ALWAYS, S_JUMP,   UA_ADD_SUM);
            UA_ADD_SUM:   return mk(F1_ADD_DR,   F2_NOP,      F3_NOP,      C_ALWAYS, S_JUMP,   UA_FETCH);
            UA_BRN:       return mk(F1_NOP,      F2_NOP,      F3_NOP,      C_NEG,    S_JUMP,   UA_BRN_TAKE);
            UA_BRN_SKIP:  return mk(F1_NOP,      F2_NOP,      F3_NOP,      C_ALWAYS, S_JUMP,   UA_FETCH);
            UA_BRN_TAKE:  return mk(F1_NOP,      F2_NOP,      F3_NOP,      C_IND,    S_CALL,   UA_IND);
            UA_BRN_LOAD:  return mk(F1_NOP,      F2_NOP,      F3_AR_TO_PC, C_ALWAYS, S_JUMP,   UA_FETCH);
            UA_STO:       return mk(F1_NOP,      F2_NOP,      F3_NOP,      C_IND,    S_CALL,   UA_IND);
            UA_STO_MOV:   return mk(F1_NOP,      F2_AC_TO_DR, F3_NOP,      C_ALWAYS, S_JUMP,   UA_STO_WR);
            UA_STO_WR:    return mk(F1_MEM_WR,   F2_NOP,      F3_NOP,      C_ALWAYS, S_JUMP,   UA_FETCH);
            UA_XCH:       return mk(F1_NOP,      F2_NOP,      F3_NOP,      C_IND,    S_CALL,   UA_IND);
            UA_XCH_RD:    return mk(F1_NOP,      F2_MEM_RD,   F3_NOP,      C_ALWAYS, S_JUMP,   UA_XCH_SWAP);
            UA_XCH_SWAP:  return mk(F1_DR_TO_AC, F2_AC_TO_DR, F3_NOP,      C_ALWAYS, S_JUMP,   UA_XCH_WR);
            UA_XCH_WR:    return mk(F1_MEM_WR,   F2_NOP,      F3_NOP,      C_ALWAYS, S_JUMP,   UA_FETCH);
            UA_FETCH:     return mk(F1_PC_TO_AR, F2_NOP,      F3_NOP,      C_ALWAYS, S_JUMP,   UA_FETCH_RD);
            UA_FETCH_RD:  return mk(F1_NOP,      F2_MEM_RD,   F3_INC_PC,   C_ALWAYS, S_JUMP,   UA_FETCH_DEC);
            UA_FETCH_DEC: return mk(F1_DR_TO_AR, F2_NOP,      F3_NOP,      C_ALWAYS, S_DECODE, UA_FETCH);
            UA_IND:       return mk(F1_NOP,      F2_MEM_RD,   F3_NOP,      C_ALWAYS, S_JUMP,   UA_IND_RET);
            UA_IND_RET:   return mk(F1_DR_TO_AR, F2_NOP,      F3_NOP,      C_ALWAYS, S_RETURN, UA_FETCH);
            default:      return mk(F1_NOP,      F2_NOP,      F3_NOP,      C_ALWAYS, S_JUMP,   UA_FETCH);
        endcase
    endfunction

endpackage

// File: rtl/uacc_cstore.sv
module uacc_cstore
    import uacc_pkg::*;
(
    input  logic [CA_W-1:0] car,
    output uinstr_t         ui
);
    always_comb begin
        ui = ucode(car);
    end
endmodule

// File: rtl/uacc_seq.sv
module uacc_seq
    import uacc_pkg::*;
#(
    parameter int OP_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  cond_e           cd,
    input  seq_e            br,
    input  logic [CA_W-1:0] ad,
    input  logic            flag_ind,
    input  logic            flag_neg,
    input  logic            flag_zero,
    input  logic [OP_W-1:0] opcode,
    output logic [CA_W-1:0] car
);
    localparam int PAD_W = CA_W - OP_W - 2;

    logic [CA_W-1:0] sbr;
    logic [CA_W-1:0] car_inc;
    logic [CA_W-1:0] car_nxt;
    logic            hit;

    always_comb begin
        case (cd)
            C_ALWAYS: hit = 1'b1;
            C_IND:    hit = flag_ind;
            C_NEG:    hit = flag_neg;
            default:  hit = flag_zero;
        endcase
    end

    assign car_inc = car + 1'b1;

    always_comb begin
        case (br)
            S_JUMP:   car_nxt = hit ? ad : car_inc;
            S_CALL:   car_nxt = hit ? ad : car_inc;
            S_RETURN: car_nxt = sbr;
            default:  car_nxt = {{PAD_W{1'b0}}, opcode, 2'b00};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            car <= UA_FETCH;
            sbr <= '0;
        end else begin
            car <= car_nxt;
            if (br == S_CALL && hit) begin
                sbr <= car_inc;
            end
        end
    end

    AST_CALL_ENTERS_SUB: assert property (@(posedge clk) disable iff (rst)
        (br == S_CALL && cd == C_IND && flag_ind) |=> (car == UA_IND)) else $error("call missed"); // R8

endmodule

// File: rtl/uacc_dp.sv
module uacc_dp
    import uacc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 11,
    parameter int OP_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  f1_e               f1,
    input  f2_e               f2,
    input  f3_e               f3,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [DATA_W-1:0] peek_data,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] ar,
    output logic [DATA_W-1:0] dr,
    output logic [DATA_W-1:0] ac,
    output logic              flag_ind,
    output logic              flag_neg,
    output logic              flag_zero,
    output logic [OP_W-1:0]   opcode
);
    localparam int MEM_WORDS = 1 << ADDR_W;
    localparam int EXT_W     = DATA_W - ADDR_W;

    logic [DATA_W-1:0] mem [MEM_WORDS];
    logic [DATA_W-1:0] mem_rd;
    logic [DATA_W-1:0] ac_nxt;
    logic [DATA_W-1:0] dr_nxt;
    logic [ADDR_W-1:0] ar_nxt;
    logic [ADDR_W-1:0] pc_nxt;

    assign mem_rd    = mem[ar];
    assign peek_data = mem[peek_addr];
    assign flag_ind  = dr[DATA_W-1];
    assign opcode    = dr[DATA_W-2 -: OP_W];
    assign flag_neg  = ac[DATA_W-1];
    assign flag_zero = (ac == '0);

    // accumulator: first field has priority over second, second over third
    always_comb begin
        ac_nxt = ac;
        case (f3)
            F3_XOR_DR: ac_nxt = ac ^ dr;
            F3_NOT_AC: ac_nxt = ~ac;
            F3_SHL_AC: ac_nxt = ac << 1;
            F3_SHR_AC: ac_nxt = ac >> 1;
            default:   ;
        endcase
        case (f2)
            F2_SUB_DR: ac_nxt = ac - dr;
            F2_OR_DR:  ac_nxt = ac | dr;
            F2_AND_DR: ac_nxt = ac & dr;
            default:   ;
        endcase
        case (f1)
            F1_ADD_DR:   ac_nxt = ac + dr;
            F1_CLR_AC:   ac_nxt = '0;
            F1_INC_AC:   ac_nxt = ac + 1'b1;
            F1_DR_TO_AC: ac_nxt = dr;
            default:     ;
        endcase
    end

    always_comb begin
        dr_nxt = dr;
        case (f2)
            F2_MEM_RD:   dr_nxt = mem_rd;
            F2_AC_TO_DR: dr_nxt = ac;
            F2_INC_DR:   dr_nxt = dr + 1'b1;
            F2_PC_TO_DR: dr_nxt = {{EXT_W{1'b0}}, pc};
            default:     ;
        endcase
    end

    always_comb begin
        ar_nxt = ar;
        case (f1)
            F1_DR_TO_AR: ar_nxt = dr[ADDR_W-1:0];
            F1_PC_TO_AR: ar_nxt = pc;
            default:     ;
        endcase
    end

    always_comb begin
        pc_nxt = pc;
        case (f3)
            F3_INC_PC:   pc_nxt = pc + 1'b1;
            F3_AR_TO_PC: pc_nxt = ar;
            default:     ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
            ar <= '0;
            dr <= '0;
            ac <= '0;
        end else begin
            pc <= pc_nxt;
            ar <= ar_nxt;
            dr <= dr_nxt;
            ac <= ac_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            if (ld_we) begin
                mem[ld_addr] <= ld_data;
            end
        end else if (f1 == F1_MEM_WR) begin
            mem[ar] <= dr;
        end
    end

    AST_READ_LOADS_DR: assert property (@(posedge clk) disable iff (rst)
        (f2 == F2_MEM_RD) |=> (dr == $past(mem_rd))) else $error("read lost"); // R4

endmodule

// File: rtl/uacc_core.sv
module uacc_core
    import uacc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [DATA_W-1:0] peek_data,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] ar_q,
    output logic [DATA_W-1:0] dr_q,
    output logic [DATA_W-1:0] ac_q,
    output logic [CA_W-1:0]   uaddr
);
    localparam int OP_W = 4;

    uinstr_t         ui;
    logic            flag_ind;
    logic            flag_neg;
    logic            flag_zero;
    logic [OP_W-1:0] opcode;

    uacc_cstore u_cstore (
        .car (uaddr),
        .ui  (ui)
    );

    uacc_seq #(.OP_W(OP_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cd        (ui.cd),
        .br        (ui.br),
        .ad        (ui.ad),
        .flag_ind  (flag_ind),
        .flag_neg  (flag_neg),
        .flag_zero (flag_zero),
        .opcode    (opcode),
        .car       (uaddr)
    );

    uacc_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OP_W(OP_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .f1        (ui.f1),
        .f2        (ui.f2),
        .f3        (ui.f3),
        .ld_we     (ld_we),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .peek_addr (peek_addr),
        .peek_data (peek_data),
        .pc        (pc_q),
        .ar        (ar_q),
        .dr        (dr_q),
        .ac        (ac_q),
        .flag_ind  (flag_ind),
        .flag_neg  (flag_neg),
        .flag_zero (flag_zero),
        .opcode    (opcode)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (uaddr == UA_FETCH && pc_q == '0 && ac_q == '0)) else $error("reset state"); // R1

    AST_FETCH_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (uaddr == UA_FETCH_RD) |=> (pc_q == $past(pc_q) + 1'b1)) else $error("pc step"); // R2

    AST_DECODE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (uaddr == UA_FETCH_DEC) |=> (uaddr[CA_W-1] == 1'b0 && uaddr[1:0] == 2'b00)) else $error("decode"); // R3

    AST_SUB_RETURN: assert property (@(posedge clk) disable iff (rst)
        (uaddr == UA_IND_RET) |=> (uaddr == UA_ADD_RD || uaddr == UA_BRN_LOAD ||
                                   uaddr == UA_STO_MOV || uaddr == UA_XCH_RD)) else $error("return"); // R8

    AST_BRANCH_LOAD: assert property (@(posedge clk) disable iff (rst)
        (uaddr == UA_BRN_LOAD) |=> (pc_q == $past(ar_q))) else $error("branch"); // R5

    AST_STORE_KEEPS_AC: assert property (@(posedge clk) disable iff (rst)
        (uaddr == UA_STO_WR) |=> $stable(ac_q)) else $error("store ac"); // R6

endmodule

// File: tb/uacc_core_bench.sv
module uacc_core_bench;
    localparam int DW = 16;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_we = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;
    logic [AW-1:0] peek_addr = '0;
    logic [DW-1:0] peek_data;
    logic [AW-1:0] pc_q;
    logic [AW-1:0] ar_q;
    logic [DW-1:0] dr_q;
    logic [DW-1:0] ac_q;
    logic [6:0]    uaddr;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    uacc_core #(.DATA_W(DW), .ADDR_W(AW)) u_uacc_core (
        .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .peek_addr(peek_addr), .peek_data(peek_data), .pc_q(pc_q), .ar_q(ar_q),
        .dr_q(dr_q), .ac_q(ac_q), .uaddr(uaddr)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [DW-1:0] enc(bit ind, int op, int adr);
        return {ind, 4'(op), 11'(adr)};
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold_reset();
        rst = 1'b1;
        @(negedge clk);
    endtask

    task automatic poke(int a, int d);
        ld_addr = AW'(a);
        ld_data = DW'(d);
        ld_we = 1'b1;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic peek(int a, output int v);
        peek_addr = AW'(a);
        #1;
        v = int'(peek_data);
    endtask

    // run one instruction; returns fetch-to-fetch cycle count
    task automatic step(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (uaddr != 7'd64 && cyc < 40);
    endtask

    task automatic t_reset();
        hold_reset();
        @(negedge clk);
        chk("R1 uaddr", int'(uaddr), 64);
        chk("R1 pc", int'(pc_q), 0);
        chk("R1 ar", int'(ar_q), 0);
        chk("R1 dr", int'(dr_q), 0);
        chk("R1 ac", int'(ac_q), 0);
    endtask

    task automatic t_add();
        int c;
        hold_reset();
        poke(0, enc(0, 0, 100));
        poke(1, enc(0, 0, 101));
        poke(2, enc(1, 0, 200));
        poke(100, 16'h0005);
        poke(101, 16'hFFFE);
        poke(200, 300);
        poke(300, 16'h0007);
        rst = 1'b0;
        step(c);
        chk("R4 add ac", int'(ac_q), 5);
        chk("R4 add cycles", c, 6);
        chk("R2 pc after fetch", int'(pc_q), 1);
        chk("R2 ar address field", int'(ar_q), 100);
        step(c);
        chk("R4 add wrap", int'(ac_q), 3);
        step(c);
        chk("R8 indirect add ac", int'(ac_q), 10);
        chk("R8 indirect add cycles", c, 8);
        chk("R8 indirect ar", int'(ar_q), 300);
    endtask

    task automatic t_branch();
        int c;
        hold_reset();
        poke(0, enc(0, 1, 50));
        rst = 1'b0;
        step(c);
        chk("R5 not taken pc", int'(pc_q), 1);
        chk("R5 not taken cycles", c, 5);
        hold_reset();
        poke(0, enc(0, 0, 100));
        poke(1, enc(0, 1, 40));
        poke(40, enc(1, 1, 60));
        poke(60, 500);
        poke(100, 16'h8001);
        rst = 1'b0;
        step(c);
        step(c);
        chk("R5 taken pc", int'(pc_q), 40);
        chk("R5 taken cycles", c, 6);
        step(c);
        chk("R5 indirect taken pc", int'(pc_q), 500);
        chk("R5 indirect taken cycles", c, 8);
    endtask

    task automatic t_store();
        int c;
        int v;
        hold_reset();
        poke(0, enc(0, 0, 100));
        poke(1, enc(0, 2, 120));
        poke(2, enc(1, 2, 121));
        poke(100, 16'h1234);
        poke(120, 0);
        poke(121, 130);
        poke(130, 0);
        rst = 1'b0;
        step(c);
        step(c);
        chk("R6 store cycles", c, 6);
        chk("R6 ac kept", int'(ac_q), 16'h1234);
        peek(120, v);
        chk("R6 store mem", v, 16'h1234);
        step(c);
        chk("R6 indirect store cycles", c, 8);
        peek(130, v);
        chk("R8 indirect store mem", v, 16'h1234);
        peek(121, v);
        chk("R8 pointer untouched", v, 130);
    endtask

    task automatic t_exchange();
        int c;
        int v;
        hold_reset();
        poke(0, enc(0, 0, 100));
        poke(1, enc(0, 3, 110));
        poke(100, 16'h00AA);
        poke(110, 16'h0F0F);
        rst = 1'b0;
        step(c);
        step(c);
        chk("R7 xch cycles", c, 7);
        chk("R7 xch ac", int'(ac_q), 16'h0F0F);
        peek(110, v);
        chk("R7 xch mem", v, 16'h00AA);
    endtask

    task automatic t_unknown();
        int c;
        int v;
        hold_reset();
        poke(0, enc(0, 0, 100));
        poke(1, enc(0, 9, 100));
        poke(2, enc(1, 15, 100));
        poke(100, 3);
        rst = 1'b0;
        step(c);
        step(c);
        chk("R9 op9 cycles", c, 4);
        chk("R3 op9 decode ac", int'(ac_q), 3);
        step(c);
        chk("R9 op15 cycles", c, 4);
        chk("R9 pc", int'(pc_q), 3);
        chk("R9 ac", int'(ac_q), 3);
        peek(100, v);
        chk("R9 mem", v, 3);
    endtask

    task automatic t_load_blocked();
        int c;
        int v;
        hold_reset();
        poke(0, enc(0, 0, 100));
        poke(100, 16'h0011);
        rst = 1'b0;
        poke(100, 16'hDEAD);
        step(c);
        chk("R10 ac", int'(ac_q), 16'h0011);
        peek(100, v);
        chk("R10 mem", v, 16'h0011);
    endtask

    initial begin
        t_reset();
        t_add();
        t_branch();
        t_store();
        t_exchange();
        t_unknown();
        t_load_blocked();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule